// File: doc/BRIEF.md
# Instruction Context Propagation Unit

This unit decides which stored instruction prefix, if any, applies to each instruction as it retires. It keeps seven independent streams. Each stream has a 24-bit prefix value, a 40-bit schedule shift register and a fill offset. A schedule bit at position k means "apply this stream's prefix to the k-th upcoming instruction". Software fills the schedules with insert commands. Each insert appends the meaningful bits of a 20-bit immediate at the selected stream's fill offset and replaces that stream's prefix.

On every retire strobe all schedules move down by one position. The stream whose bottom schedule bit is set drives the applied prefix. The output is combinational from the stored state, so the context for the retiring instruction is valid in the same cycle as the strobe.

The unit guarantees that no two streams claim the same instruction by checking each insert before it commits. A clashing insert is dropped and reported on a one-cycle exception pulse. Schedule overflow and an out-of-range stream index are reported on the same pulse.

Top module: `ctx_prop_unit`

## Requirements
- R1: After reset every schedule is empty, every fill offset is 0, `ctx_valid`, `ctx_prefix` and `exc` are all 0, and the first insert into any stream lands at schedule position 0.
- R2: The append length of an insert is the index of the highest set bit of `ins_imm` plus one. It is 0 for an all-zero immediate. The stream's fill offset advances by that length.
- R3: Immediate bit i is written to schedule position offset+i. The bit at position k causes the stream's prefix to be applied to the instruction retiring after exactly k further strobes.
- R4: An insert into a valid, non-clashing stream replaces that stream's prefix. The new prefix also applies to schedule bits inserted earlier in that stream. This holds even for an all-zero immediate.
- R5: While a stream's schedule bit 0 is 1, `ctx_valid` is 1 and `ctx_prefix` shows that stream's prefix. On a `step` cycle every schedule shifts right by one and every nonzero offset drops by one. Without `step` or an insert, the schedules do not change.
- R6: When no stream has schedule bit 0 set, `ctx_valid` is 0 and `ctx_prefix` is 0.
- R7: If any bit placed by an insert coincides with a set bit of another stream's schedule, the insert is dropped. The schedules, offsets and prefixes keep their values, and `exc` is 1 in the following cycle.
- R8: If offset plus append length exceeds 40, the bits that fit are stored, the offset becomes 40, and `exc` is 1 in the following cycle. A fill offset never exceeds 40.
- R9: An insert with `ins_stream` equal to 7 changes nothing and raises `exc` in the following cycle.
- R10: When insert and `step` occur in the same cycle, the clash check uses the state before the shift. The appended bits are merged first and the result is then shifted. The offset becomes the post-insert offset minus one, saturating at 0.
- R11: `exc` is high only in the cycle after an insert that was flagged under R7, R8 or R9. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert command this cycle |
| ins_stream | input | 3 | Target stream index (0 to 6 valid) |
| ins_imm | input | 20 | Schedule bits to append, bit 0 first |
| ins_prefix | input | 24 | New prefix for the target stream |
| step | input | 1 | An instruction retires this cycle |
| ctx_valid | output | 1 | A stream claims the retiring instruction |
| ctx_prefix | output | 24 | Prefix of the claiming stream, else 0 |
| exc | output | 1 | One-cycle pulse after a rejected or truncated insert |

## Verification
Single-bit immediates are walked through all twenty positions. Each must surface after exactly its own number of strobes, which separates correct placement and append length from off-by-one errors in either. Dense all-ones immediates fill one stream to the top and then past it, which tells clean truncation apart from wrap-around or a lost offset. Targeted pairs of inserts probe the remaining rules: overlaps between streams, an index of 7, an all-zero immediate and a strobe in the same cycle as an insert. A long pseudo-random mix of sparse and dense immediates with random strobes then compares every cycle against an arithmetic model of the schedules and offsets.

// File: rtl/ctxp_pkg.sv
package ctxp_pkg;
   // reason an insert is flagged; FLT_NONE means a clean insert or none
   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_INDEX = 2'd1,
      FLT_CLASH = 2'd2,
      FLT_OVER  = 2'd3
   } fault_e;
endpackage

// File: rtl/ctxp_span.sv
// Append length of an immediate: position of its highest set bit plus one.
module ctxp_span #(
   parameter int IMM_W = 20,
   parameter int CNT_W = 5
) (
   input  logic [IMM_W-1:0] imm,
   output logic [CNT_W-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < IMM_W; i++) begin
         if (imm[i]) cnt = CNT_W'(i + 1);
      end
   end
endmodule

// File: rtl/ctxp_slot.sv
// One stream: schedule shift register, fill offset and stored prefix.
module ctxp_slot #(
   parameter int SCHED_W  = 40,
   parameter int PREFIX_W = 24,
   parameter int OFF_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SCHED_W-1:0]  load_bits,
   input  logic [OFF_W-1:0]    load_off,
   input  logic [PREFIX_W-1:0] load_prefix,
   input  logic                step,
   output logic [SCHED_W-1:0]  sched_o,
   output logic [OFF_W-1:0]    off_o,
   output logic [PREFIX_W-1:0] prefix_o
);
   logic [SCHED_W-1:0]  sched_q, merged;
   logic [OFF_W-1:0]    off_q, base_off;
   logic [PREFIX_W-1:0] pfx_q;

   always_comb begin
      merged   = load ? (sched_q | load_bits) : sched_q;
      base_off = load ? load_off : off_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sched_q <= '0;
         off_q   <= '0;
         pfx_q   <= '0;
      end else begin
         sched_q <= step ? (merged >> 1) : merged;
         off_q   <= (step && (base_off != '0)) ? base_off - OFF_W'(1) : base_off;
         if (load) pfx_q <= load_prefix;
      end
   end

   assign sched_o  = sched_q;
   assign off_o    = off_q;
   assign prefix_o = pfx_q;
endmodule

// File: rtl/ctxp_select.sv
// Picks the prefix of the stream whose schedule bit 0 is set.
module ctxp_select #(
   parameter int NUM_STREAMS = 7,
   parameter int PREFIX_W    = 24,
   parameter bit ONEHOT_MUX  = 1'b1
) (
   input  logic [NUM_STREAMS-1:0]          lsb,
   input  logic [NUM_STREAMS*PREFIX_W-1:0] pfx_flat,
   output logic                            valid,
   output logic [PREFIX_W-1:0]             pfx
);
   assign valid = |lsb;

   generate
      if (ONEHOT_MUX) begin : g_andor
         // relies on the insert-time clash check keeping lsb one-hot
         always_comb begin
            pfx = '0;
            for (int i = 0; i < NUM_STREAMS; i++)
               pfx |= pfx_flat[i*PREFIX_W +: PREFIX_W] & {PREFIX_W{lsb[i]}};
         end
      end else begin : g_prio
         // lowest index wins
         always_comb begin
            pfx = '0;
            for (int i = NUM_STREAMS - 1; i >= 0; i--)
               if (lsb[i]) pfx = pfx_flat[i*PREFIX_W +: PREFIX_W];
         end
      end
   endgenerate
endmodule

// File: rtl/ctx_prop_unit.sv
module ctx_prop_unit
   import ctxp_pkg::*;
#(
   parameter int NUM_STREAMS = 7,
   parameter int SCHED_W     = 40,
   parameter int PREFIX_W    = 24,
   parameter int IMM_W       = 20,
   parameter int IDX_W       = 3,
   parameter bit ONEHOT_MUX  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ins_valid,
   input  logic [IDX_W-1:0]    ins_stream,
   input  logic [IMM_W-1:0]    ins_imm,
   input  logic [PREFIX_W-1:0] ins_prefix,
   input  logic                step,
   output logic                ctx_valid,
   output logic [PREFIX_W-1:0] ctx_prefix,
   output logic                exc
);
   localparam int OFF_W  = $clog2(SCHED_W + 1);
   localparam int CNT_W  = $clog2(IMM_W + 1);
   localparam int WIDE_W = SCHED_W + IMM_W;

   // elaboration-time parameter checks
   generate
      if (IMM_W > SCHED_W) begin : g_err_imm
         $error("ctx_prop_unit: IMM_W must not exceed SCHED_W");
      end
      if ((1 << IDX_W) < NUM_STREAMS) begin : g_err_idx
         $error("ctx_prop_unit: IDX_W too narrow for NUM_STREAMS");
      end
      if (NUM_STREAMS < 2) begin : g_err_num
         $error("ctx_prop_unit: need at least two streams");
      end
   endgenerate

   logic [SCHED_W-1:0]  sched [NUM_STREAMS];
   logic [OFF_W-1:0]    offs  [NUM_STREAMS];
   logic [PREFIX_W-1:0] pfx   [NUM_STREAMS];

   logic [NUM_STREAMS-1:0]          sel_oh;
   logic [NUM_STREAMS-1:0]          lsb_vec;
   logic [NUM_STREAMS*PREFIX_W-1:0] pfx_flat;
   logic [NUM_STREAMS*SCHED_W-1:0]  sched_flat;
   logic [NUM_STREAMS*OFF_W-1:0]    offs_flat;

   logic                idx_ok;
   logic [OFF_W-1:0]    off_sel;
   logic [SCHED_W-1:0]  others;
   logic [WIDE_W-1:0]   placed_wide;
   logic [SCHED_W-1:0]  placed;
   logic [CNT_W-1:0]    cnt;
   logic [OFF_W-1:0]    fill;
   logic [OFF_W-1:0]    new_off;
   logic                over;
   logic                clash;
   logic                commit;
   fault_e              fault;
   logic                exc_q;

   // ---------------- target decode ----------------
   assign idx_ok = ({1'b0, ins_stream} < (IDX_W+1)'(NUM_STREAMS));

   always_comb begin
      for (int i = 0; i < NUM_STREAMS; i++)
         sel_oh[i] = ins_valid && (ins_stream == IDX_W'(i));
   end

   always_comb begin
      off_sel = '0;
      others  = '0;
      for (int i = 0; i < NUM_STREAMS; i++) begin
         if (sel_oh[i]) off_sel |= offs[i];
         else           others  |= sched[i];
      end
   end

   // ---------------- placement ----------------
   ctxp_span #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_span (
      .imm (ins_imm),
      .cnt (cnt)
   );

   assign placed_wide = WIDE_W'(ins_imm) << off_sel;
   assign placed      = placed_wide[SCHED_W-1:0];
   // the top set bit of the immediate lands above the register iff offset+len > SCHED_W
   assign over        = |placed_wide[WIDE_W-1:SCHED_W];
   assign fill        = off_sel + OFF_W'(cnt);
   assign new_off     = over ? OFF_W'(SCHED_W) : fill;
   assign clash       = |(placed & others);

   always_comb begin
      if (!ins_valid)   fault = FLT_NONE;
      else if (!idx_ok) fault = FLT_INDEX;
      else if (clash)   fault = FLT_CLASH;
      else if (over)    fault = FLT_OVER;
      else              fault = FLT_NONE;
   end

   assign commit = ins_valid && idx_ok && !clash;

   // ---------------- streams ----------------
   generate
      for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_slot
         ctxp_slot #(
            .SCHED_W  (SCHED_W),
            .PREFIX_W (PREFIX_W),
            .OFF_W    (OFF_W)
         ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (commit && sel_oh[g]),
            .load_bits   (placed),
            .load_off    (new_off),
            .load_prefix (ins_prefix),
            .step        (step),
            .sched_o     (sched[g]),
            .off_o       (offs[g]),
            .prefix_o    (pfx[g])
         );
         assign lsb_vec[g]                            = sched[g][0];
         assign pfx_flat[g*PREFIX_W +: PREFIX_W]      = pfx[g];
         assign sched_flat[g*SCHED_W +: SCHED_W]      = sched[g];
         assign offs_flat[g*OFF_W +: OFF_W]           = offs[g];
      end
   endgenerate

   // ---------------- output ----------------
   ctxp_select #(
      .NUM_STREAMS (NUM_STREAMS),
      .PREFIX_W    (PREFIX_W),
      .ONEHOT_MUX  (ONEHOT_MUX)
   ) u_select (
      .lsb      (lsb_vec),
      .pfx_flat (pfx_flat),
      .valid    (ctx_valid),
      .pfx      (ctx_prefix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) exc_q <= 1'b0;
      else        exc_q <= (fault != FLT_NONE);
   end

   assign exc = exc_q;
endmodule

// File: rtl/ctx_prop_unit_chk.sv
module ctx_prop_unit_chk #(
   parameter int NUM_STREAMS = 7,
   parameter int SCHED_W     = 40,
   parameter int PREFIX_W    = 24,
   parameter int IDX_W       = 3,
   parameter int OFF_W       = 6
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           ins_valid,
   input logic [IDX_W-1:0]               ins_stream,
   input logic                           step,
   input logic                           ctx_valid,
   input logic [PREFIX_W-1:0]            ctx_prefix,
   input logic                           exc,
   input logic                           clash,
   input logic [NUM_STREAMS-1:0]         lsb_vec,
   input logic [NUM_STREAMS*SCHED_W-1:0] sched_flat,
   input logic [NUM_STREAMS*OFF_W-1:0]   offs_flat
);
   logic bad_idx;
   assign bad_idx = ins_valid && ({1'b0, ins_stream} >= (IDX_W+1)'(NUM_STREAMS));

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctx_valid |-> (ctx_prefix == '0));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid && !step) |=> ($stable(sched_flat) && $stable(ctx_prefix) && $stable(ctx_valid)));

   p_single_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lsb_vec));

   p_clash_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && clash && !step) |=> ($stable(sched_flat) && $stable(offs_flat)));

   p_clash_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && clash) |=> exc);

   p_bad_index_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_idx |=> exc);

   p_bad_index_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_idx && !step) |=> ($stable(sched_flat) && $stable(offs_flat) && $stable(ctx_prefix)));

   p_exc_after_insert_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> !exc);

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NUM_STREAMS; i++) begin
            p_off_bound_r8: assert (offs_flat[i*OFF_W +: OFF_W] <= OFF_W'(SCHED_W))
               else $error("offset of stream %0d above schedule length", i);
         end
      end
   end
endmodule

bind ctx_prop_unit ctx_prop_unit_chk #(
   .NUM_STREAMS (NUM_STREAMS),
   .SCHED_W     (SCHED_W),
   .PREFIX_W    (PREFIX_W),
   .IDX_W       (IDX_W),
   .OFF_W       (OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ins_valid  (ins_valid),
   .ins_stream (ins_stream),
   .step       (step),
   .ctx_valid  (ctx_valid),
   .ctx_prefix (ctx_prefix),
   .exc        (exc),
   .clash      (clash),
   .lsb_vec    (lsb_vec),
   .sched_flat (sched_flat),
   .offs_flat  (offs_flat)
);

// File: tb/ctx_prop_unit_tb.sv
`timescale 1ns/1ps
module ctx_prop_unit_tb;
   localparam int NS = 7;
   localparam int SW = 40;
   localparam int PW = 24;
   localparam int IW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic [2:0]    ins_stream = '0;
   logic [IW-1:0] ins_imm = '0;
   logic [PW-1:0] ins_prefix = '0;
   logic          step = 1'b0;
   logic          ctx_valid;
   logic [PW-1:0] ctx_prefix;
   logic          exc;

   always #2.5 clk = ~clk;

   ctx_prop_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_stream(ins_stream),
      .ins_imm(ins_imm), .ins_prefix(ins_prefix), .step(step),
      .ctx_valid(ctx_valid), .ctx_prefix(ctx_prefix), .exc(exc)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // arithmetic model of the requirements
   logic [SW-1:0] ms [NS];
   int            mo [NS];
   logic [PW-1:0] mp [NS];
   string         exp_why = "";
   string         cur_tag = "";

   task automatic chk(bit ok, string tag, string what, longint act, longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic int span(logic [IW-1:0] v);
      int n = 0;
      for (int i = 0; i < IW; i++) if (v[i]) n = i + 1;
      return n;
   endfunction

   task automatic model_reset();
      for (int j = 0; j < NS; j++) begin
         ms[j] = '0; mo[j] = 0; mp[j] = '0;
      end
      exp_why = "";
   endtask

   task automatic model(bit iv, int idx, logic [IW-1:0] imm, logic [PW-1:0] pfx, bit st);
      logic [SW+IW-1:0] w;
      logic [SW-1:0]    pl, oth;
      int               c;
      exp_why = "";
      if (iv) begin
         if (idx >= NS) exp_why = "R9";
         else begin
            c   = span(imm);
            w   = {{SW{1'b0}}, imm} << mo[idx];
            pl  = w[SW-1:0];
            oth = '0;
            for (int j = 0; j < NS; j++) if (j != idx) oth |= ms[j];
            if ((pl & oth) != '0) exp_why = "R7";
            else begin
               ms[idx] |= pl;
               mp[idx]  = pfx;
               if (mo[idx] + c > SW) begin exp_why = "R8"; mo[idx] = SW; end
               else mo[idx] += c;
            end
         end
      end
      if (st) begin
         for (int j = 0; j < NS; j++) begin
            ms[j] = ms[j] >> 1;
            if (mo[j] > 0) mo[j]--;
         end
      end
   endtask

   task automatic check_ctx();
      bit            ev = 1'b0;
      logic [PW-1:0] ep = '0;
      string         tag;
      for (int j = NS - 1; j >= 0; j--) if (ms[j][0]) begin ev = 1'b1; ep = mp[j]; end
      tag = (cur_tag != "") ? cur_tag : (ev ? "R5" : "R6");
      chk(ctx_valid == ev, tag, "ctx_valid", ctx_valid, ev);
      chk(ctx_prefix == ep, tag, "ctx_prefix", ctx_prefix, ep);
   endtask

   // one cycle: drive at negedge, check outputs before the edge, check exc after
   task automatic cyc(bit iv, int idx, logic [IW-1:0] imm, logic [PW-1:0] pfx, bit st);
      bit eexc;
      @(negedge clk);
      ins_valid  = iv;
      ins_stream = 3'(idx);
      ins_imm    = imm;
      ins_prefix = pfx;
      step       = st;
      #1;
      check_ctx();
      model(iv, idx, imm, pfx, st);
      eexc = (exp_why != "");
      @(posedge clk);
      #1;
      chk(exc == eexc, eexc ? exp_why : "R11", "exc", exc, eexc);
   endtask

   task automatic drain(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, '0, '0, 1'b1);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(ctx_valid == 1'b0, "R1", "ctx_valid in reset", ctx_valid, 0);
      chk(ctx_prefix == '0, "R1", "ctx_prefix in reset", ctx_prefix, 0);
      chk(exc == 1'b0, "R1", "exc in reset", exc, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: first insert lands at position 0 (prefix applies at once)
      cur_tag = "R1";
      cyc(1'b1, 3, 20'h00001, 24'hA1A1A1, 1'b0);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b0, 0, '0, '0, 1'b0);

      // R2 R3: walk a single bit through every immediate position
      cur_tag = "R3";
      for (int k = 0; k < IW; k++) begin
         cyc(1'b1, k % NS, IW'(1) << k, PW'(32'h10000 + k), 1'b0);
         for (int s = 0; s <= k; s++) cyc(1'b0, 0, '0, '0, 1'b1);
      end
      cyc(1'b0, 0, '0, '0, 1'b0);

      // R2: empty immediate appends nothing, next bit lands at old offset
      cur_tag = "R2";
      cyc(1'b1, 0, 20'h00000, 24'h00BEEF, 1'b0);
      cyc(1'b1, 0, 20'h00001, 24'h00CAFE, 1'b0);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b1, 2, 20'h00009, 24'h002222, 1'b0); // offset 0 -> bits 0 and 3
      drain(5);

      // R4: prefix replaced, also for bits already queued
      cur_tag = "R4";
      cyc(1'b1, 1, 20'h00005, 24'h111111, 1'b0);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b1, 1, 20'h00000, 24'h222222, 1'b0);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b0, 0, '0, '0, 1'b0);
      drain(3);

      // R7: clash aborts and flags; victim offset untouched
      cur_tag = "R7";
      cyc(1'b1, 2, 20'h00001, 24'h333333, 1'b0);
      cyc(1'b1, 3, 20'h00003, 24'h444444, 1'b0);   // overlaps bit 0
      cyc(1'b1, 3, 20'h00002, 24'h555555, 1'b0);   // bit 1 only, lands at 1
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b0, 0, '0, '0, 1'b1);
      drain(3);

      // R8: overflow truncates, offset pinned at top
      cur_tag = "R8";
      cyc(1'b1, 4, 20'hFFFFF, 24'h666666, 1'b0);
      cyc(1'b1, 4, 20'hFFFFF, 24'h666666, 1'b0);
      cyc(1'b1, 4, 20'h00001, 24'h777777, 1'b0);   // 40+1 > 40
      drain(5);
      cyc(1'b1, 4, 20'h003FF, 24'h888888, 1'b0);   // 35+10 > 40, 5 stored
      drain(SW + 2);

      // R9: stream index 7 changes nothing
      cur_tag = "R9";
      cyc(1'b1, 5, 20'h00002, 24'h999999, 1'b0);
      cyc(1'b1, 7, 20'h00001, 24'hDEAD00, 1'b0);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b1, 7, 20'h00001, 24'hDEAD01, 1'b1);
      drain(2);

      // R10: insert and step in the same cycle
      cur_tag = "R10";
      cyc(1'b1, 5, 20'h00003, 24'hABCDEF, 1'b1);   // bit0 dropped, bit1 -> 0
      cyc(1'b1, 5, 20'h00001, 24'hFEDCBA, 1'b0);   // offset 1
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b0, 0, '0, '0, 1'b1);
      cyc(1'b1, 6, 20'h00001, 24'h0F0F0F, 1'b1);
      drain(3);

      // pseudo-random sweep against the model
      cur_tag = "";
      lfsr = 32'h1ACE5EED;
      for (int n = 0; n < 4000; n++) begin
         logic [IW-1:0] imm;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[9:8] == 2'b00) imm = IW'(20'hFFFFF) >> (lfsr[20:16] % IW);
         else                    imm = IW'(1) << (lfsr[20:16] % IW);
         if (lfsr[12:10] == 3'b000) imm = '0;
         cyc(lfsr[3] & lfsr[4], int'(lfsr[7:5]), imm, PW'(lfsr[31:8]), lfsr[2]);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule